// File: doc/BRIEF.md
# Predicated Two-Slot Execute Stage

This block is the execute and write-enable stage of a small two-issue datapath whose bundles are scheduled statically. Each cycle it takes one bundle of two operations. It reads their operands from a general register file and a small predicate register file, computes the results and drives one register write port per slot. The general and predicate registers are updated on the next rising clock edge.

Every operation except a branch names a guard predicate. When the guard is false, the operation is squashed: it writes neither a general register nor a predicate. Compare operations load a predicate pair with a result and its complement. A then-path operation guarded by one predicate and an else-path operation guarded by the other can then share a bundle, with no branch between them. Two conditional moves turn a zero or nonzero test on an operand into a write qualifier. A short if-then-else can therefore be written as straight-line data flow.

Fetch, decode from memory, branch resolution and hazard detection are outside the block. A branch only raises a per-slot pulse for a later stage to act on.

Top module: `pred_exec_stage`

## Requirements
- R1: After reset all 16 general registers read zero, predicates 1 to 7 read false and predicate 0 reads true.
- R2: Opcodes ADD=1, SUB=2, AND=3, OR=4, XOR=5 write the result of srca op srcb to dst. LDI=11 writes the zero-extended 8-bit value {srca field, srcb field} to dst. For a live operation, the write enable, address (equal to dst) and data appear in the same cycle, and the register holds the new value after the next rising edge. Opcodes 0 and 12 to 15 have no effect.
- R3: An operation whose guard predicate (the guard field, 0 to 7) is false drives its write enable low and leaves every general and predicate register unchanged.
- R4: MOVZ=6 writes the value of register srca to dst only when register srcb equals zero. Otherwise it does not write.
- R5: MOVNZ=7 writes the value of register srca to dst only when register srcb is nonzero. Otherwise it does not write.
- R6: CMPLT=8 (signed less-than) and CMPEQ=9 never write a general register. A live compare sets the predicate indexed by dst[2:0] to the result and the predicate indexed by the pneg field to its complement. If both indices are equal, the complement is stored.
- R7: Predicate 0 stays true: predicate writes aimed at it are dropped, and an operation guarded by it is always live.
- R8: BR=10 raises br_fire for its slot whenever the bundle is valid, whatever its guard, and never writes a general register.
- R9: All operand and guard reads of a bundle see the register state from before that bundle's writes, so two operations in one bundle can exchange registers.
- R10: When both slots write the same general register in one bundle, the slot 1 value is stored.
- R11: While bundle_valid is low, no write enable or br_fire is raised and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bundle_valid_i | input | 1 | The bundle on the inputs is to be executed |
| op_i | input | 2x4 | Opcode per slot |
| dst_i | input | 2x4 | Destination register per slot; bits [2:0] give the true-predicate index of a compare |
| srca_i | input | 2x4 | First source register per slot |
| srcb_i | input | 2x4 | Second source register or test operand per slot |
| guard_i | input | 2x3 | Guard predicate index per slot |
| pneg_i | input | 2x3 | Predicate that receives a compare's complement, per slot |
| wr_en_o | output | 2 | Register write enable per slot |
| wr_addr_o | output | 2x4 | Register write address per slot |
| wr_data_o | output | 2x32 | Register write data per slot |
| br_fire_o | output | 2 | Branch taken effect per slot |

## Verification
The checker assumes that operand reads come from state that only this block's own write ports change, and that reset is applied before the first bundle. Given that, any cycle without a write enable must leave the general registers stable. The bench drives bundles only from the negative clock edge, with reset asserted first. Apart from reset, it changes state only through bundles, so every register write in the run is one the model predicted. The random sweep draws all sixteen opcode codes, every register and predicate index, and occasional invalid bundles. The model sees the same pre-bundle state, so guarded writes, conditional moves and predicate pairs can be predicted bit for bit.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_MOVZ  = 4'd6,
    OP_MOVNZ = 4'd7,
    OP_CMPLT = 4'd8,
    OP_CMPEQ = 4'd9,
    OP_BR    = 4'd10,
    OP_LDI   = 4'd11
  } pxs_op_e;
endpackage

// File: rtl/pxs_regfile.sv
module pxs_regfile #(
  parameter int XLEN = 32,
  parameter int NGPR = 16,
  parameter int NWR  = 2,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NGPR)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][AW-1:0]    rd_addr_i,
  output logic [NRD-1:0][XLEN-1:0]  rd_data_o,
  input  logic [NWR-1:0]            we_i,
  input  logic [NWR-1:0][AW-1:0]    wa_i,
  input  logic [NWR-1:0][XLEN-1:0]  wd_i,
  output logic [NGPR-1:0][XLEN-1:0] state_o
);
  logic [NGPR-1:0][XLEN-1:0] mem_q, mem_d;
  logic                      mem_en;

  // later write ports override earlier ones
  always_comb begin
    mem_d = mem_q;
    for (int w = 0; w < NWR; w++) begin
      if (we_i[w]) mem_d[wa_i[w]] = wd_i[w];
    end
  end

  assign mem_en = |we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_addr_i[r]];
  end

  assign state_o = mem_q;
endmodule

// File: rtl/pxs_predfile.sv
module pxs_predfile #(
  parameter int NPRED = 8,
  parameter int NSLOT = 2,
  localparam int PW   = $clog2(NPRED)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOT-1:0][PW-1:0] rd_idx_i,
  output logic [NSLOT-1:0]         rd_val_o,
  input  logic [NSLOT-1:0]         we_i,
  input  logic [NSLOT-1:0][PW-1:0] tidx_i,
  input  logic [NSLOT-1:0][PW-1:0] fidx_i,
  input  logic [NSLOT-1:0]         val_i,
  output logic [NPRED-1:0]         state_o
);
  localparam logic [NPRED-1:0] RST_VAL = {{(NPRED-1){1'b0}}, 1'b1};

  logic [NPRED-1:0] p_q, p_d;
  logic             p_en;

  // slot order, then true before complement; index 0 forced back to true
  always_comb begin
    p_d = p_q;
    for (int s = 0; s < NSLOT; s++) begin
      if (we_i[s]) begin
        p_d[tidx_i[s]] = val_i[s];
        p_d[fidx_i[s]] = ~val_i[s];
      end
    end
    p_d[0] = 1'b1;
  end

  assign p_en = |we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= RST_VAL;
    end else if (p_en) begin
      p_q <= p_d;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_rd
    assign rd_val_o[s] = p_q[rd_idx_i[s]];
  end

  assign state_o = p_q;
endmodule

// File: rtl/pxs_slot.sv
module pxs_slot import pxs_pkg::*; #(
  parameter int XLEN = 32,
  parameter int AW   = 4
) (
  input  logic            valid_i,
  input  logic [OPW-1:0]  op_i,
  input  logic [AW-1:0]   srca_i,
  input  logic [AW-1:0]   srcb_i,
  input  logic [XLEN-1:0] a_val_i,
  input  logic [XLEN-1:0] b_val_i,
  input  logic            guard_ok_i,
  output logic            wr_en_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            pw_en_o,
  output logic            pw_val_o,
  output logic            br_o
);
  localparam int IMMW = 2 * AW;

  pxs_op_e         op;
  logic            live;
  logic            b_zero;
  logic            commit;
  logic            pset;
  logic            pval;
  logic [XLEN-1:0] res;

  assign op     = pxs_op_e'(op_i);
  assign live   = valid_i & guard_ok_i;
  assign b_zero = (b_val_i == '0);

  always_comb begin
    res    = '0;
    commit = 1'b0;
    pset   = 1'b0;
    pval   = 1'b0;
    case (op)
      OP_ADD:   begin res = a_val_i + b_val_i; commit = 1'b1; end
      OP_SUB:   begin res = a_val_i - b_val_i; commit = 1'b1; end
      OP_AND:   begin res = a_val_i & b_val_i; commit = 1'b1; end
      OP_OR:    begin res = a_val_i | b_val_i; commit = 1'b1; end
      OP_XOR:   begin res = a_val_i ^ b_val_i; commit = 1'b1; end
      OP_LDI:   begin res = {{(XLEN-IMMW){1'b0}}, srca_i, srcb_i}; commit = 1'b1; end
      OP_MOVZ:  begin res = a_val_i; commit = b_zero;  end
      OP_MOVNZ: begin res = a_val_i; commit = ~b_zero; end
      OP_CMPLT: begin pset = 1'b1; pval = ($signed(a_val_i) < $signed(b_val_i)); end
      OP_CMPEQ: begin pset = 1'b1; pval = (a_val_i == b_val_i); end
      default:  ;
    endcase
  end

  assign wr_en_o   = live & commit;
  assign wr_data_o = res;
  assign pw_en_o   = live & pset;
  assign pw_val_o  = pval;
  assign br_o      = valid_i & (op == OP_BR);
endmodule

// File: rtl/pred_exec_stage.sv
module pred_exec_stage import pxs_pkg::*; #(
  parameter int XLEN  = 32,
  parameter int NGPR  = 16,
  parameter int NPRED = 8,
  localparam int AW   = $clog2(NGPR),
  localparam int PW   = $clog2(NPRED)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bundle_valid_i,
  input  logic [1:0][OPW-1:0]    op_i,
  input  logic [1:0][AW-1:0]     dst_i,
  input  logic [1:0][AW-1:0]     srca_i,
  input  logic [1:0][AW-1:0]     srcb_i,
  input  logic [1:0][PW-1:0]     guard_i,
  input  logic [1:0][PW-1:0]     pneg_i,
  output logic [1:0]             wr_en_o,
  output logic [1:0][AW-1:0]     wr_addr_o,
  output logic [1:0][XLEN-1:0]   wr_data_o,
  output logic [1:0]             br_fire_o
);
  localparam int NSLOT = 2;
  localparam int NRD   = 2 * NSLOT;

  logic [NRD-1:0][AW-1:0]     rd_addr;
  logic [NRD-1:0][XLEN-1:0]   rd_data;
  logic [NSLOT-1:0]           guard_ok;
  logic [NSLOT-1:0]           pw_en;
  logic [NSLOT-1:0]           pw_val;
  logic [NSLOT-1:0][PW-1:0]   ptrue_idx;
  logic [NGPR-1:0][XLEN-1:0]  gpr_state;
  logic [NPRED-1:0]           pred_state;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign rd_addr[2*s]   = srca_i[s];
    assign rd_addr[2*s+1] = srcb_i[s];
    assign ptrue_idx[s]   = dst_i[s][PW-1:0];
    assign wr_addr_o[s]   = dst_i[s];

    pxs_slot #(.XLEN(XLEN), .AW(AW)) slot_i (
      .valid_i    (bundle_valid_i),
      .op_i       (op_i[s]),
      .srca_i     (srca_i[s]),
      .srcb_i     (srcb_i[s]),
      .a_val_i    (rd_data[2*s]),
      .b_val_i    (rd_data[2*s+1]),
      .guard_ok_i (guard_ok[s]),
      .wr_en_o    (wr_en_o[s]),
      .wr_data_o  (wr_data_o[s]),
      .pw_en_o    (pw_en[s]),
      .pw_val_o   (pw_val[s]),
      .br_o       (br_fire_o[s])
    );
  end

  pxs_regfile #(.XLEN(XLEN), .NGPR(NGPR), .NWR(NSLOT), .NRD(NRD)) gpr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .we_i      (wr_en_o),
    .wa_i      (wr_addr_o),
    .wd_i      (wr_data_o),
    .state_o   (gpr_state)
  );

  pxs_predfile #(.NPRED(NPRED), .NSLOT(NSLOT)) prf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_i (guard_i),
    .rd_val_o (guard_ok),
    .we_i     (pw_en),
    .tidx_i   (ptrue_idx),
    .fidx_i   (pneg_i),
    .val_i    (pw_val),
    .state_o  (pred_state)
  );
endmodule

// File: rtl/pxs_chk.sv
module pxs_chk import pxs_pkg::*; #(
  parameter int XLEN  = 32,
  parameter int NGPR  = 16,
  parameter int NPRED = 8,
  localparam int AW   = $clog2(NGPR)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bundle_valid,
  input logic [1:0][OPW-1:0]       op,
  input logic [1:0]                wr_en,
  input logic [1:0][AW-1:0]        wr_addr,
  input logic [1:0][XLEN-1:0]      wr_data,
  input logic [1:0]                br_fire,
  input logic [NGPR-1:0][XLEN-1:0] gpr_q,
  input logic [NPRED-1:0]          pred_q
);
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bundle_valid |-> (wr_en == 2'b00 && br_fire == 2'b00));

  assert_cmp_nowrite0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op[0] == OP_CMPLT || op[0] == OP_CMPEQ) |-> !wr_en[0]);

  assert_cmp_nowrite1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op[1] == OP_CMPLT || op[1] == OP_CMPEQ) |-> !wr_en[1]);

  assert_branch_nowrite0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    br_fire[0] |-> !wr_en[0]);

  assert_branch_nowrite1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    br_fire[1] |-> !wr_en[1]);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == 2'b00) |=> $stable(gpr_q));

  assert_slot1_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[1] |=> gpr_q[$past(wr_addr[1])] == $past(wr_data[1]));

  assert_slot0_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[0] && !(wr_en[1] && wr_addr[1] == wr_addr[0]))
      |=> gpr_q[$past(wr_addr[0])] == $past(wr_data[0]));

  assert_p0_true_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pred_q[0]);
endmodule

bind pred_exec_stage pxs_chk #(.XLEN(XLEN), .NGPR(NGPR), .NPRED(NPRED)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bundle_valid (bundle_valid_i),
  .op           (op_i),
  .wr_en        (wr_en_o),
  .wr_addr      (wr_addr_o),
  .wr_data      (wr_data_o),
  .br_fire      (br_fire_o),
  .gpr_q        (gpr_state),
  .pred_q       (pred_state)
);

// File: tb/pred_exec_stage_tb_top.sv
`timescale 1ns/1ps
module pred_exec_stage_tb_top;
  localparam int K_ADD = 1, K_SUB = 2, K_AND = 3, K_OR = 4, K_XOR = 5;
  localparam int K_MOVZ = 6, K_MOVNZ = 7, K_CMPLT = 8, K_CMPEQ = 9;
  localparam int K_BR = 10, K_LDI = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic bval;
  logic [1:0][3:0]  op_r, d_r, a_r, b_r;
  logic [1:0][2:0]  g_r, n_r;
  logic [1:0]       wr_en, br_fire;
  logic [1:0][3:0]  wr_addr;
  logic [1:0][31:0] wr_data;

  logic [31:0] gm [16];
  bit          pm [8];
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pred_exec_stage dut_i (
    .clk(clk), .rst_n(rst_n), .bundle_valid_i(bval),
    .op_i(op_r), .dst_i(d_r), .srca_i(a_r), .srcb_i(b_r),
    .guard_i(g_r), .pneg_i(n_r),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .br_fire_o(br_fire)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_slot(input int s, input int o, input int dd, input int aa,
                          input int bb, input int gg, input int nn);
    op_r[s] = 4'(o); d_r[s] = 4'(dd); a_r[s] = 4'(aa);
    b_r[s]  = 4'(bb); g_r[s] = 3'(gg); n_r[s] = 3'(nn);
  endtask

  function automatic string auto_tag(input int o, input bit gok);
    if (!bval) return "R11";
    if (o == K_BR) return "R8";
    if (!gok) return "R3";
    case (o)
      K_MOVZ:           return "R4";
      K_MOVNZ:          return "R5";
      K_CMPLT, K_CMPEQ: return "R6";
      default:          return "R2";
    endcase
  endfunction

  // called at a negative edge with inputs already driven
  task automatic step(input string tag);
    bit [1:0] een, pen, pvv, ebr;
    logic [1:0][31:0] ed;
    string t;
    #1;
    for (int s = 0; s < 2; s++) begin
      logic [31:0] av, bv2;
      bit gok, live;
      gok  = pm[g_r[s]];
      live = bval && gok;
      av   = gm[a_r[s]];
      bv2  = gm[b_r[s]];
      een[s] = 0; pen[s] = 0; pvv[s] = 0; ed[s] = '0;
      ebr[s] = bval && (op_r[s] == 4'(K_BR));
      case (int'(op_r[s]))
        K_ADD:   begin ed[s] = av + bv2; een[s] = live; end
        K_SUB:   begin ed[s] = av - bv2; een[s] = live; end
        K_AND:   begin ed[s] = av & bv2; een[s] = live; end
        K_OR:    begin ed[s] = av | bv2; een[s] = live; end
        K_XOR:   begin ed[s] = av ^ bv2; een[s] = live; end
        K_LDI:   begin ed[s] = {24'h0, a_r[s], b_r[s]}; een[s] = live; end
        K_MOVZ:  begin ed[s] = av; een[s] = live && (bv2 == 0); end
        K_MOVNZ: begin ed[s] = av; een[s] = live && (bv2 != 0); end
        K_CMPLT: begin pen[s] = live; pvv[s] = ($signed(av) < $signed(bv2)); end
        K_CMPEQ: begin pen[s] = live; pvv[s] = (av == bv2); end
        default: ;
      endcase
      t = (tag != "") ? tag : auto_tag(int'(op_r[s]), gok);
      chk(wr_en[s] === een[s], t, $sformatf("slot%0d wr_en", s), 32'(wr_en[s]), 32'(een[s]));
      chk(br_fire[s] === ebr[s], t, $sformatf("slot%0d br_fire", s), 32'(br_fire[s]), 32'(ebr[s]));
      if (een[s]) begin
        chk(wr_addr[s] === d_r[s], t, $sformatf("slot%0d wr_addr", s), 32'(wr_addr[s]), 32'(d_r[s]));
        chk(wr_data[s] === ed[s], t, $sformatf("slot%0d wr_data", s), wr_data[s], ed[s]);
      end
    end
    @(posedge clk);
    for (int s = 0; s < 2; s++) if (een[s]) gm[d_r[s]] = ed[s];
    for (int s = 0; s < 2; s++) begin
      if (pen[s]) begin
        if (d_r[s][2:0] != 0) pm[d_r[s][2:0]] = pvv[s];
        if (n_r[s] != 0) pm[n_r[s]] = !pvv[s];
      end
    end
    @(negedge clk);
  endtask

  task automatic rd2(input int x, input int y, input string tag);
    bval = 1'b1;
    set_slot(0, K_OR, x, x, x, 0, 0);
    set_slot(1, K_OR, y, y, y, 0, 0);
    step(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bval = 1'b0;
    set_slot(0, 0, 0, 0, 0, 0, 0);
    set_slot(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) gm[i] = '0;
    for (int i = 0; i < 8; i++) pm[i] = (i == 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of registers and predicates
    for (int i = 0; i < 16; i += 2) rd2(i, i + 1, "R1");
    for (int p = 1; p < 8; p++) begin
      bval = 1'b1;
      set_slot(0, K_OR, 1, 1, 1, p, 0);
      set_slot(1, K_OR, 2, 2, 2, 0, 0);
      step("R1");
    end

    // R2: load every register with a distinct value
    for (int i = 1; i < 16; i += 2) begin
      int v0 = $urandom_range(1, 255);
      int v1 = $urandom_range(1, 255);
      bval = 1'b1;
      set_slot(0, K_LDI, i, v0 >> 4, v0 & 15, 0, 0);
      set_slot(1, K_LDI, (i + 1) & 15, v1 >> 4, v1 & 15, 0, 0);
      step("R2");
    end

    // R9: swap through one bundle, then read back
    bval = 1'b1;
    set_slot(0, K_LDI, 1, 1, 1, 0, 0);
    set_slot(1, K_LDI, 2, 2, 2, 0, 0);
    step("R9");
    set_slot(0, K_OR, 1, 2, 2, 0, 0);
    set_slot(1, K_OR, 2, 1, 1, 0, 0);
    step("R9");
    rd2(1, 2, "R9");
    chk(gm[1] == 32'h22 && gm[2] == 32'h11, "R9", "swap model", gm[1], 32'h22);

    // R10: same destination in both slots
    set_slot(0, K_LDI, 5, 0, 10, 0, 0);
    set_slot(1, K_LDI, 5, 0, 11, 0, 0);
    step("R10");
    rd2(5, 5, "R10");
    chk(gm[5] == 32'h0b, "R10", "slot1 value kept", gm[5], 32'h0b);

    // R7: compare aimed at predicate 0 does not clear it
    set_slot(0, K_CMPLT, 0, 2, 1, 0, 0);
    set_slot(1, K_CMPLT, 0, 1, 2, 0, 0);
    step("R7");
    set_slot(0, K_OR, 3, 3, 3, 0, 0);
    set_slot(1, K_OR, 4, 4, 4, 0, 0);
    step("R7");

    // R6: predicate pair, then then/else paths sharing one bundle
    set_slot(0, K_CMPLT, 3, 1, 2, 0, 4);
    set_slot(1, K_NOPIDX(), 0, 0, 0, 0, 0);
    step("R6");
    set_slot(0, K_LDI, 6, 3, 3, 3, 0);
    set_slot(1, K_LDI, 6, 4, 4, 4, 0);
    step("R6");
    rd2(6, 6, "R6");
    chk(gm[6] == 32'h44, "R6", "else path kept", gm[6], 32'h44);

    // R4 / R5: conditional moves on a zero and a nonzero test register
    set_slot(0, K_LDI, 7, 0, 0, 0, 0);
    set_slot(1, K_LDI, 8, 0, 0, 0, 0);
    step("R4");
    set_slot(0, K_MOVZ, 8, 1, 7, 0, 0);
    set_slot(1, K_MOVNZ, 9, 1, 7, 0, 0);
    step("R4");
    set_slot(0, K_MOVZ, 10, 2, 1, 0, 0);
    set_slot(1, K_MOVNZ, 11, 2, 1, 0, 0);
    step("R5");
    rd2(8, 9, "R4");
    rd2(10, 11, "R5");

    // R8: branch under a false guard still fires
    set_slot(0, K_BR, 0, 0, 0, 3, 0);
    set_slot(1, K_BR, 0, 0, 0, 0, 0);
    step("R8");

    // R11: invalid bundle writes nothing
    bval = 1'b0;
    set_slot(0, K_LDI, 12, 15, 15, 0, 0);
    set_slot(1, K_BR, 12, 15, 15, 0, 0);
    step("R11");
    rd2(12, 12, "R11");

    // sweep: random bundles over all codes and indices
    for (int it = 0; it < 400; it++) begin
      bval = ($urandom_range(0, 9) != 0);
      for (int s = 0; s < 2; s++)
        set_slot(s, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                 $urandom_range(0, 15), $urandom_range(0, 7), $urandom_range(0, 7));
      step("");
    end
    for (int i = 0; i < 16; i += 2) rd2(i, i + 1, "R3");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  function automatic int K_NOPIDX();
    return 0;
  endfunction
endmodule